// File: doc/BRIEF.md
# Self-Timed Program/Erase Sequencer

This block sits behind the command front end of a serial nonvolatile memory model. The front end decodes each serial instruction and hands it over as a one-cycle command strobe with an operation code, a word address and a data word. The sequencer keeps the write-enable latch and arms a pending program operation (single-word write, single-word erase, whole-array erase, whole-array write). It launches a self-timed programming cycle when chip select falls. The cycle needs no serial clocks. Its length is set by a cycle-count parameter standing in for the program time.

Once the cycle has entered its programming phase, raising chip select makes the data-out pin report busy (low) or ready (high). The host can release the pin to high impedance by shifting a 1 into the data-in pin. The storage array is behavioural: one register per word, with an asynchronous read port that is independent of the enable state.

Chip select must stay low for a minimum number of clocks after the command. If it rises earlier, the pending operation is abandoned and the array is left untouched.

Top module: `prog_seq_top`

## Requirements
- R1: A command is taken only in a cycle where `cmd_valid` is 1, `cs` is 1 and `busy` is 0; a strobe with `cs` low has no effect. Operation codes on `cmd_op`: 1 write word, 2 erase word, 3 erase all, 4 write all, 5 enable programming, 6 disable programming, 0 none.
- R2: After reset the block is programming-disabled, `busy` and `do_oe` are 0 and every word reads all ones. Program commands taken while disabled are dropped: a following `cs` fall starts no cycle and the array is unchanged.
- R3: Code 5 enables programming, and the enable persists across any number of program cycles. Code 6 disables it again, after which program commands are dropped.
- R4: `rd_data` always shows the stored word at `rd_addr`, whatever the enable state.
- R5: When `cs` falls after an armed program command, `busy` is 1 from the next clock for exactly CS_MIN_LOW + PROG_CYCLES clocks, with `sk` idle.
- R6: If `cs` rises before it has been low for CS_MIN_LOW clocks, the cycle is abandoned: `busy` returns to 0 on the next clock and the array is unchanged.
- R7: Erase word sets the addressed word to all ones. Erase all sets every word to all ones.
- R8: Write word stores the data whatever the old contents, leaving other words alone. Write all stores the data into every word, whatever the old contents.
- R9: The array changes only on the clock edge that ends the cycle. On the last busy clock the old contents still read back.
- R10: Once the programming phase has begun, `do_oe` equals `cs`, and `do_out` is 0 while busy and 1 when ready. With `cs` low, `do_oe` is 0.
- R11: With `cs` high, a 1 on `di` at an `sk` rising edge releases `do_oe` to 0 after the next `sk` falling edge, and not before. A 0 on `di` has no effect.
- R12: Commands of every code are ignored while `busy` is 1, including enable and disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select level, synchronous to clk |
| sk | input | 1 | Serial clock level, sampled by clk |
| di | input | 1 | Serial data-in level |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of the command |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Read port data |
| busy | output | 1 | Programming cycle in progress |
| do_oe | output | 1 | Data-out drive enable (0 = high impedance) |
| do_out | output | 1 | Data-out level while driven (ready/busy) |

## Verification
On every clock, the assertions check these properties:
- A cycle begins only on a chip-select fall.
- No cycle outlasts its programmed length.
- The data-out pin is driven only while selected, and shows ready when idle.
- A driven pin is released only by an accepted command or a serial clock falling edge.
- The array holds still whenever no cycle has just ended.

Only the bench scenarios can show the rest:
- The enable latch's memory across cycles, and commands dropped while disabled or busy.
- The exact cycle boundaries and the abandonment of a short chip-select low window.
- The per-word and whole-array contents after erase and write sweeps.

// File: rtl/prog_seq_pkg.sv
// Shared types for the program/erase sequencer.
// Assumes the command front end presents operation codes in prog_op_e.
package prog_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_ERAL  = 3'd3,
        OP_WRAL  = 3'd4,
        OP_EWEN  = 3'd5,
        OP_EWDS  = 3'd6
    } prog_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;

    // True for the operations that need a self-timed cycle.
    function automatic logic is_prog_op(prog_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_ERAL)  || (op == OP_WRAL);
    endfunction

endpackage

// File: rtl/prog_edge_sense.sv
// Edge detector for the chip-select and serial-clock levels.
// Assumes cs and sk are already synchronous to clk.
// Resets the history to low, so no fall is seen right after reset.
module prog_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    output logic cs_fall,
    output logic sk_rise,
    output logic sk_fall
);

    logic cs_q;
    logic sk_q;

    // Hold last-cycle levels of cs and sk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    // Decode transitions from the current and previous levels.
    always_comb begin
        cs_fall = cs_q & ~cs;
        sk_rise = ~sk_q & sk;
        sk_fall = sk_q & ~sk;
    end

endmodule

// File: rtl/prog_wen_latch.sv
// Programming-enable latch.
// Resets to disabled; it is set by an accepted enable command and cleared
// by an accepted disable command. Assumes take is already gated by busy.
module prog_wen_latch
    import prog_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     take,
    input  prog_op_e op,
    output logic     wen
);

    // Update the latch on accepted enable/disable commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= 1'b0;
        end else if (take && (op == OP_EWEN)) begin
            wen <= 1'b1;
        end else if (take && (op == OP_EWDS)) begin
            wen <= 1'b0;
        end
    end

endmodule

// File: rtl/prog_cycle_ctrl.sv
// Arms a pending program operation and runs the self-timed cycle.
// Flow: IDLE -> (cs fall with an armed op) -> QUAL (cs-low window)
//       -> PROG (PROG_CYCLES clocks) -> IDLE, with commit on the last clock.
// If cs rises during QUAL, the operation is dropped.
// Assumes CS_MIN_LOW >= 1 and PROG_CYCLES >= 1.
module prog_cycle_ctrl
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int CS_MIN_LOW  = 4,
    parameter int PROG_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  prog_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              wen,
    input  logic              cs,
    input  logic              cs_fall,
    output logic              busy,
    output logic              arm_set,
    output logic              commit,
    output prog_op_e          c_op,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data
);

    localparam int CNT_MAX = (CS_MIN_LOW > PROG_CYCLES) ? CS_MIN_LOW : PROG_CYCLES;
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(CS_MIN_LOW - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    prog_op_e          p_op;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;
    logic              load;

    // Accept a program operation only while enabled.
    always_comb load = take && is_prog_op(op) && wen;

    // Pending operation register; armed is dropped on any cs fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            p_op   <= OP_NONE;
            p_addr <= '0;
            p_data <= '0;
        end else if (load) begin
            armed  <= 1'b1;
            p_op   <= op;
            p_addr <= addr;
            p_data <= data;
        end else if (cs_fall) begin
            armed  <= 1'b0;
        end
    end

    // Cycle state machine with a shared phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cs_fall && armed) begin
                        state <= ST_QUAL;
                        cnt   <= '0;
                    end
                end
                ST_QUAL: begin
                    if (cs) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (cnt == QUAL_LAST) begin
                        state <= ST_PROG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Phase outputs and the committed operation fields.
    always_comb begin
        busy    = (state != ST_IDLE);
        arm_set = (state == ST_QUAL) && !cs && (cnt == QUAL_LAST);
        commit  = (state == ST_PROG) && (cnt == PROG_LAST);
        c_op    = p_op;
        c_addr  = p_addr;
        c_data  = p_data;
    end

endmodule

// File: rtl/prog_status_out.sv
// Ready/busy driver for the data-out pin.
// Status is armed when the programming phase starts. It is driven only
// while cs is high, and is released by an accepted command or by a
// dummy 1 (di high at sk rise, taking effect at the next sk fall).
module prog_status_out (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic di,
    input  logic sk_rise,
    input  logic sk_fall,
    input  logic arm_set,
    input  logic take,
    input  logic busy,
    output logic do_oe,
    output logic do_out
);

    logic arm;
    logic rel_pend;

    // Status arm flag: set at cycle start, cleared by release or command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
        end else if (arm_set) begin
            arm <= 1'b1;
        end else if (take) begin
            arm <= 1'b0;
        end else if (sk_fall && rel_pend) begin
            arm <= 1'b0;
        end
    end

    // Remember a dummy 1 seen on an sk rise until the following sk fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pend <= 1'b0;
        end else if (!cs) begin
            rel_pend <= 1'b0;
        end else if (sk_rise && di) begin
            rel_pend <= 1'b1;
        end else if (sk_fall) begin
            rel_pend <= 1'b0;
        end
    end

    // Drive the ready level while selected and armed.
    always_comb begin
        do_oe  = cs & arm;
        do_out = arm & ~busy;
    end

endmodule

// File: rtl/prog_word_array.sv
// Behavioural word array, one register per word, blank (all ones) at reset.
// On commit it updates one word or broadcasts to all of them in a single clock.
// Erase operations store all ones; write operations store the data directly.
module prog_word_array
    import prog_seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  prog_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] word_bus [DEPTH];
    logic              all_words;
    logic [DATA_W-1:0] fill;

    // Select broadcast and the stored value for the committed operation.
    always_comb begin
        all_words = (op == OP_ERAL) || (op == OP_WRAL);
        fill      = ((op == OP_ERASE) || (op == OP_ERAL)) ? '1 : data;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Word storage: update on a matching or broadcast commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (commit && (all_words || (addr == ADDR_W'(i)))) begin
                word_q <= fill;
            end
        end

        assign word_bus[i] = word_q;
    end

    // Asynchronous read port.
    always_comb rd_data = word_bus[rd_addr];

endmodule

// File: rtl/prog_seq_top.sv
// Self-timed program/erase sequencer top level.
// Takes decoded commands from the front end, holds the enable latch,
// runs the chip-select-launched program cycle, drives ready/busy status
// on data-out and owns the behavioural word array.
// Assumes cs, sk and di are synchronous to clk.
module prog_seq_top
    import prog_seq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 16,
    parameter int CS_MIN_LOW  = 4,
    parameter int PROG_CYCLES = 50,
    localparam int ADDR_W     = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              do_oe,
    output logic              do_out
);

    prog_op_e          op_in;
    logic              take;
    logic              wen;
    logic              cs_fall;
    logic              sk_rise;
    logic              sk_fall;
    logic              arm_set;
    logic              commit;
    prog_op_e          c_op;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;

    // Command acceptance: selected, strobed and idle.
    always_comb begin
        op_in = prog_op_e'(cmd_op);
        take  = cmd_valid & cs & ~busy;
    end

    prog_edge_sense u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .cs_fall (cs_fall),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall)
    );

    prog_wen_latch u_wen (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .op    (op_in),
        .wen   (wen)
    );

    prog_cycle_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CS_MIN_LOW  (CS_MIN_LOW),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .op      (op_in),
        .addr    (cmd_addr),
        .data    (cmd_data),
        .wen     (wen),
        .cs      (cs),
        .cs_fall (cs_fall),
        .busy    (busy),
        .arm_set (arm_set),
        .commit  (commit),
        .c_op    (c_op),
        .c_addr  (c_addr),
        .c_data  (c_data)
    );

    prog_status_out u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .di      (di),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall),
        .arm_set (arm_set),
        .take    (take),
        .busy    (busy),
        .do_oe   (do_oe),
        .do_out  (do_out)
    );

    prog_word_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .op      (c_op),
        .addr    (c_addr),
        .data    (c_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/prog_seq_checker.sv
// Port-level properties of the sequencer, bound into prog_seq_top.
// A busy-length counter replaces a long parameterised delay window.
module prog_seq_checker #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int CS_MIN_LOW  = 4,
    parameter int PROG_CYCLES = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              sk,
    input logic              cmd_valid,
    input logic              busy,
    input logic              do_oe,
    input logic              do_out,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);

    localparam int CYCLE_LEN = CS_MIN_LOW + PROG_CYCLES;

    int blen;

    // Count consecutive busy clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) blen <= 0;
        else if (busy) blen <= blen + 1;
        else blen <= 0;
    end

    AST_START_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(cs) && $past(cs, 2)));                 // R5

    AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen < CYCLE_LEN));                                   // R5

    AST_DO_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe |-> cs);                                                  // R10

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && !busy) |-> do_out);                                   // R10

    AST_RELEASE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(do_oe) && cs && $past(cs)) |->
            ($past(cmd_valid) || ($past(sk, 2) && !$past(sk))));        // R11

    AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && $stable(rd_addr)) |-> $stable(rd_data));       // R9

endmodule

bind prog_seq_top prog_seq_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CS_MIN_LOW  (CS_MIN_LOW),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .sk        (sk),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .do_oe     (do_oe),
    .do_out    (do_out),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/tb_prog_seq_top.sv
`timescale 1ns/100ps
module tb_prog_seq_top;
    import prog_seq_pkg::*;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CSM   = 3;
    localparam int PROG  = 12;
    localparam int TLEN  = CSM + PROG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [3:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic busy, do_oe, do_out;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] model [DEPTH];

    always #10 clk = ~clk;

    prog_seq_top #(.DEPTH(DEPTH), .DATA_W(DW), .CS_MIN_LOW(CSM), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .do_oe(do_oe), .do_out(do_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input prog_op_e op, input int a, input int d);
        @(negedge clk);
        cs = 1'b1; cmd_valid = 1'b1; cmd_op = op;
        cmd_addr = 4'(a); cmd_data = DW'(d);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = OP_NONE;
    endtask

    task automatic check_array(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 4'(a);
            #0.5;
            chk(rd_data == model[a], req, rd_data, model[a]);
        end
    endtask

    task automatic model_apply(input prog_op_e op, input int a, input int d);
        case (op)
            OP_WRITE: model[a] = DW'(d);
            OP_ERASE: model[a] = '1;
            OP_ERAL:  for (int i = 0; i < DEPTH; i++) model[i] = '1;
            OP_WRAL:  for (int i = 0; i < DEPTH; i++) model[i] = DW'(d);
            default: ;
        endcase
    endtask

    // Drop cs and follow the cycle; expect tells whether a cycle should run.
    task automatic fire(input bit expect_run, input prog_op_e op, input int a,
                        input int d, input string req);
        string btag;
        btag = expect_run ? "R5" : req;
        @(negedge clk);
        cs = 1'b0;
        cyc(1);
        chk(busy == expect_run, btag, busy, expect_run);
        cyc(TLEN - 1);
        chk(busy == expect_run, btag, busy, expect_run);
        rd_addr = 4'(a);
        #0.5;
        chk(rd_data == model[a], "R9", rd_data, model[a]);
        cyc(1);
        chk(busy == 1'b0, btag, busy, 0);
        if (expect_run) model_apply(op, a, d);
        check_array(req);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R2 reset state
        chk(busy == 1'b0, "R2", busy, 0);
        chk(do_oe == 1'b0, "R2", do_oe, 0);
        check_array("R2");

        // R2: program command dropped while disabled
        send(OP_WRITE, 3, 8'h5A);
        fire(1'b0, OP_WRITE, 3, 8'h5A, "R2");

        // R3/R8: enable once, then sweep writes over every word
        send(OP_EWEN, 0, 0);
        for (int a = 0; a < DEPTH; a++) begin
            send(OP_WRITE, a, (a * 37 + 5) & 8'hFF);
            fire(1'b1, OP_WRITE, a, (a * 37 + 5) & 8'hFF, "R8");
        end

        // R4: reads unaffected by disable; R3: disable drops erase
        send(OP_EWDS, 0, 0);
        check_array("R4");
        send(OP_ERASE, 5, 0);
        fire(1'b0, OP_ERASE, 5, 0, "R3");

        // R7/R8: erase, overwrite, broadcast operations
        send(OP_EWEN, 0, 0);
        send(OP_ERASE, 5, 0);
        fire(1'b1, OP_ERASE, 5, 0, "R7");
        send(OP_WRITE, 5, 8'h33);
        fire(1'b1, OP_WRITE, 5, 8'h33, "R8");
        send(OP_WRITE, 6, 8'h00);
        fire(1'b1, OP_WRITE, 6, 8'h00, "R8");
        send(OP_ERAL, 0, 0);
        fire(1'b1, OP_ERAL, 0, 0, "R7");
        send(OP_WRAL, 0, 8'hC3);
        fire(1'b1, OP_WRAL, 0, 8'hC3, "R8");
        send(OP_WRITE, 2, 8'h11);
        fire(1'b1, OP_WRITE, 2, 8'h11, "R8");

        // R6: cs raised inside the minimum low window
        send(OP_WRITE, 9, 8'h77);
        @(negedge clk);
        cs = 1'b0;
        cyc(1);
        chk(busy == 1'b1, "R6", busy, 1);
        cs = 1'b1;
        cyc(1);
        chk(busy == 1'b0, "R6", busy, 0);
        cs = 1'b0;
        cyc(TLEN + 2);
        chk(busy == 1'b0, "R6", busy, 0);
        check_array("R6");

        // R1: strobe with cs low is ignored
        @(negedge clk);
        cs = 1'b0; cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_addr = 4'd10; cmd_data = 8'hAB;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = OP_NONE; cs = 1'b1;
        fire(1'b0, OP_WRITE, 10, 8'hAB, "R1");

        // R10/R12: status during the cycle, disable ignored while busy
        send(OP_WRITE, 4, 8'h44);
        @(negedge clk);
        cs = 1'b0;
        cyc(CSM + 1);
        chk(do_oe == 1'b0, "R10", do_oe, 0);
        cs = 1'b1;
        #0.5;
        chk(do_oe == 1'b1, "R10", do_oe, 1);
        chk(do_out == 1'b0, "R10", do_out, 0);
        send(OP_EWDS, 0, 0);
        for (int i = 0; i < 50 && busy; i++) cyc(1);
        model_apply(OP_WRITE, 4, 8'h44);
        chk(busy == 1'b0, "R10", busy, 0);
        chk(do_oe == 1'b1, "R10", do_oe, 1);
        chk(do_out == 1'b1, "R10", do_out, 1);

        // R11: dummy 0 keeps drive, dummy 1 releases after sk fall
        @(negedge clk); di = 1'b0; sk = 1'b1;
        @(negedge clk); sk = 1'b0;
        @(negedge clk);
        chk(do_oe == 1'b1, "R11", do_oe, 1);
        di = 1'b1; sk = 1'b1;
        @(negedge clk);
        chk(do_oe == 1'b1, "R11", do_oe, 1);
        sk = 1'b0;
        @(negedge clk);
        chk(do_oe == 1'b0, "R11", do_oe, 0);
        di = 1'b0;
        cs = 1'b0;

        // R12: enable survived the ignored disable
        send(OP_WRITE, 8, 8'h88);
        fire(1'b1, OP_WRITE, 8, 8'h88, "R12");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule